// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers playback audio on its way to a codec link. A host writes 32-bit words through a write strobe. Each word becomes one or two 20-bit samples, left-aligned according to the selected sample width, and the samples are stored in a FIFO whose depth is a parameter. Samples leave as stereo pairs (left, then right) on a 40-bit ready/valid output. Draining is gated by a transmit enable and by the two audio slot selects. A new burst starts only once the FIFO holds at least half its depth. Once a burst is running, pairs keep leaving until the sink refuses one or fewer than two samples remain.

The block keeps four status flags: empty, half-empty, full and underrun. From these it derives three interrupt sources, which are reported in a 7-bit status word and combined with a mask into a single interrupt line. Dropping the interface enable flushes the FIFO and returns every flag to its reset value.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, and one cycle after `if_enable` is low at a clock edge, the block reports `st_empty`=1, `st_half`=1, `st_full`=0, `st_underrun`=0 and `sink_valid`=0. Writes made while `if_enable` is low store nothing.
- R2: `size_code` selects the sample width: 0=16 bits, 1=18, 2=20, 3=12. In single mode, one accepted write stores `wr_data` shifted left by 4, 2, 0 or 8 respectively, truncated to 20 bits.
- R3: In packed mode (`compact_req`=1 with width 16 or 12), one write stores two samples. `wr_data[15:0]` is stored first, then `wr_data[31:16]`. Each is shifted left by 8 for 12-bit width and by 4 otherwise, and kept to 20 bits. With width 18 or 20, `compact_req` is ignored and single mode applies.
- R4: A single-mode write is dropped when the FIFO holds DEPTH samples. A packed write is dropped unless level+2 < DEPTH.
- R5: `sink_valid` is asserted only while `tx_enable`=1 and at least one bit of `slot_sel` is set. A burst starts when the level is at least DEPTH/2. `sink_data[39:20]` carries the older sample (left) and `sink_data[19:0]` the next one (right). A pair is removed on every cycle with `sink_valid` and `sink_ready` both high.
- R6: After a transfer, `sink_valid` stays high while at least two samples remain, even below DEPTH/2. It drops one cycle after a cycle with `sink_valid`=1 and `sink_ready`=0.
- R7: After a write that stores samples, `st_empty` and `st_underrun` clear, `st_half` clears if level ≥ DEPTH/2, and `st_full` sets if level = DEPTH.
- R8: After a pair leaves, `st_full` clears, `st_half` sets if level ≤ DEPTH/2, and `st_underrun` and `st_empty` set if level reaches 0.
- R9: A one-cycle `clr_underrun` pulse clears `st_underrun` when no pair leaves in that cycle.
- R10: `int_raw` is {4'b0, complete, half-empty, underrun}, where bit 0 follows `st_underrun`, bit 1 follows `st_half`, and bit 2 is `st_empty` with no burst in progress. `irq` is the OR of `int_raw[2:0] & irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_enable | input | 1 | Interface enable; low flushes the FIFO and flags |
| tx_enable | input | 1 | Transmit enable |
| slot_sel | input | 2 | Audio slot selects (bit 0 slot 3, bit 1 slot 4) |
| size_code | input | 2 | Sample width code |
| compact_req | input | 1 | Request two 16-bit halves per write |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 32 | Write word |
| clr_underrun | input | 1 | Underrun clear pulse |
| irq_mask | input | 3 | Interrupt enable mask |
| sink_valid | output | 1 | Stereo pair available |
| sink_ready | input | 1 | Sink accepts the pair |
| sink_data | output | 40 | Left sample [39:20], right sample [19:0] |
| st_empty | output | 1 | FIFO empty |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | FIFO full |
| st_underrun | output | 1 | Underrun flag |
| int_raw | output | 7 | Raw interrupt status |
| irq | output | 1 | Masked interrupt |

## Verification
Flags change at the edge that samples a write, a pop or a clear, so they are checked at the falling edge that follows. `sink_valid` and `sink_data` are decoded from the stored level and the burst state, so they are valid one cycle after the write that brings the level to half the depth. A refused pair ends a burst one cycle later. The complete bit rises one cycle after the last pair leaves. The bench fills the FIFO only while no pair can leave, so its expected-sample queue always matches the stored level. The monitor then compares every handshake against the head of that queue.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
   localparam int SAMPLE_W = 20;

   typedef enum logic [1:0] {
      SZ_16 = 2'd0,
      SZ_18 = 2'd1,
      SZ_20 = 2'd2,
      SZ_12 = 2'd3
   } size_code_t;

   // Single-mode alignment: left-justify the sample in a 20-bit field.
   function automatic logic [SAMPLE_W-1:0] align_single(input logic [31:0] w, input size_code_t sz);
      logic [SAMPLE_W-1:0] r;
      case (sz)
         SZ_12:   r = {w[11:0], 8'h00};
         SZ_16:   r = {w[15:0], 4'h0};
         SZ_18:   r = {w[17:0], 2'b00};
         default: r = w[19:0];
      endcase
      return r;
   endfunction

   // Two samples per word are only legal for the narrow widths.
   function automatic logic packing_allowed(input size_code_t sz);
      return (sz == SZ_16) || (sz == SZ_12);
   endfunction
endpackage

// File: rtl/atx_pack.sv
module atx_pack
   import audio_tx_pkg::*;
(
   input  logic [31:0]         wr_data,
   input  logic [1:0]          size_code,
   input  logic                compact_req,
   output logic                packed_mode,
   output logic [SAMPLE_W-1:0] samp0,
   output logic [SAMPLE_W-1:0] samp1
);
   localparam int LANES = 2;

   size_code_t          sz;
   logic [15:0]         half_w [LANES];
   logic [SAMPLE_W-1:0] lane_s [LANES];

   assign sz = size_code_t'(size_code);
   assign packed_mode = compact_req && packing_allowed(sz);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign half_w[i] = wr_data[16*i +: 16];
      assign lane_s[i] = (sz == SZ_12) ? {half_w[i][11:0], 8'h00} : {half_w[i], 4'h0};
   end

   assign samp0 = packed_mode ? lane_s[0] : align_single(wr_data, sz);
   assign samp1 = lane_s[1];
endmodule

// File: rtl/atx_store.sv
module atx_store
   import audio_tx_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                push_one,
   input  logic                push_two,
   input  logic [SAMPLE_W-1:0] din0,
   input  logic [SAMPLE_W-1:0] din1,
   input  logic                pop,
   output logic [SAMPLE_W-1:0] dout0,
   output logic [SAMPLE_W-1:0] dout1,
   output logic [LW-1:0]       level,
   output logic [LW-1:0]       level_nxt
);
   logic [SAMPLE_W-1:0] mem [DEPTH];
   logic [AW-1:0]       wp_q, rp_q, wp_1, rp_1;
   logic [LW-1:0]       level_q;
   logic [1:0]          n_in;

   assign n_in      = push_two ? 2'd2 : (push_one ? 2'd1 : 2'd0);
   assign wp_1      = wp_q + AW'(1);
   assign rp_1      = rp_q + AW'(1);
   assign level_nxt = level_q + LW'(n_in) - (pop ? LW'(2) : LW'(0));
   assign level     = level_q;
   assign dout0     = mem[rp_q];
   assign dout1     = mem[rp_1];

   always_ff @(posedge clk) begin
      if (push_one || push_two) mem[wp_q] <= din0;
      if (push_two)             mem[wp_1] <= din1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         level_q <= '0;
      end else if (clear) begin
         wp_q    <= '0;
         rp_q    <= '0;
         level_q <= '0;
      end else begin
         wp_q    <= wp_q + AW'(n_in);
         if (pop) rp_q <= rp_q + AW'(2);
         level_q <= level_nxt;
      end
   end
endmodule

// File: rtl/atx_flags.sv
module atx_flags #(
   parameter int DEPTH = 8,
   localparam int LW = $clog2(DEPTH) + 1,
   localparam int HALF = DEPTH / 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          pushed,
   input  logic          popped,
   input  logic          clr_underrun,
   input  logic [LW-1:0] level_nxt,
   output logic          half_q,
   output logic          under_q
);
   logic half_n, under_n;

   // Order of updates: clear pulse, then push rules, then drain rules.
   always_comb begin
      half_n  = half_q;
      under_n = under_q;
      if (clr_underrun) under_n = 1'b0;
      if (pushed) begin
         if (level_nxt != '0)            under_n = 1'b0;
         if (level_nxt >= LW'(HALF))     half_n  = 1'b0;
      end
      if (popped) begin
         if (level_nxt <= LW'(HALF))     half_n  = 1'b1;
         if (level_nxt == '0)            under_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= 1'b1;
         under_q <= 1'b0;
      end else if (clear) begin
         half_q  <= 1'b1;
         under_q <= 1'b0;
      end else begin
         half_q  <= half_n;
         under_q <= under_n;
      end
   end
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
   import audio_tx_pkg::*;
#(
   parameter int DEPTH = 8
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        if_enable,
   input  logic        tx_enable,
   input  logic [1:0]  slot_sel,
   input  logic [1:0]  size_code,
   input  logic        compact_req,
   input  logic        wr_valid,
   input  logic [31:0] wr_data,
   input  logic        clr_underrun,
   input  logic [2:0]  irq_mask,
   output logic        sink_valid,
   input  logic        sink_ready,
   output logic [39:0] sink_data,
   output logic        st_empty,
   output logic        st_half,
   output logic        st_full,
   output logic        st_underrun,
   output logic [6:0]  int_raw,
   output logic        irq
);
   localparam int AW   = $clog2(DEPTH);
   localparam int LW   = AW + 1;
   localparam int HALF = DEPTH / 2;

   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("audio_tx_fifo: DEPTH must be a power of two, at least 8");
   end

   logic                packed_mode, push_one, push_two, pop, clear, burst_q, tx_done;
   logic [SAMPLE_W-1:0] samp0, samp1, dout0, dout1;
   logic [LW-1:0]       level, level_nxt;
   logic [LW:0]         level_plus2;

   assign clear       = !if_enable;
   assign level_plus2 = {1'b0, level} + (LW+1)'(2);

   atx_pack u_pack (
      .wr_data     (wr_data),
      .size_code   (size_code),
      .compact_req (compact_req),
      .packed_mode (packed_mode),
      .samp0       (samp0),
      .samp1       (samp1)
   );

   assign push_one = wr_valid && if_enable && !packed_mode && (level < LW'(DEPTH));
   assign push_two = wr_valid && if_enable &&  packed_mode && (level_plus2 < (LW+1)'(DEPTH));

   // Burst gating: starts at half depth, then runs on until refused.
   assign sink_valid = if_enable && tx_enable && (slot_sel != 2'b00) &&
                       (level >= LW'(2)) && ((level >= LW'(HALF)) || burst_q);
   assign pop        = sink_valid && sink_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     burst_q <= 1'b0;
      else if (clear) burst_q <= 1'b0;
      else            burst_q <= pop;
   end

   atx_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .push_one  (push_one),
      .push_two  (push_two),
      .din0      (samp0),
      .din1      (samp1),
      .pop       (pop),
      .dout0     (dout0),
      .dout1     (dout1),
      .level     (level),
      .level_nxt (level_nxt)
   );

   atx_flags #(.DEPTH(DEPTH)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (clear),
      .pushed       (push_one || push_two),
      .popped       (pop),
      .clr_underrun (clr_underrun),
      .level_nxt    (level_nxt),
      .half_q       (st_half),
      .under_q      (st_underrun)
   );

   assign sink_data   = {dout0, dout1};
   assign st_empty    = (level == '0);
   assign st_full     = (level == LW'(DEPTH));
   assign tx_done     = st_empty && !burst_q;
   assign int_raw     = {4'b0000, tx_done, st_half, st_underrun};
   assign irq         = |(int_raw[2:0] & irq_mask);
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       if_enable,
   input logic       tx_enable,
   input logic [1:0] slot_sel,
   input logic       clr_underrun,
   input logic [2:0] irq_mask,
   input logic       sink_valid,
   input logic       sink_ready,
   input logic       st_empty,
   input logic       st_half,
   input logic       st_full,
   input logic       st_underrun,
   input logic       irq
);
   assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !if_enable |=> (st_empty && st_half && !st_full && !st_underrun && !sink_valid));

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (if_enable && st_full && !(sink_valid && sink_ready)) |=> st_full);

   assert_drain_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sink_valid |-> (if_enable && tx_enable && slot_sel != 2'b00));

   assert_full_not_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_full |-> !st_half);

   assert_underrun_at_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_underrun) |-> st_empty);

   assert_clear_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (if_enable && clr_underrun && !(sink_valid && sink_ready)) |=> !st_underrun);

   assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 3'b000) |-> !irq);
endmodule

bind audio_tx_fifo atx_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .if_enable    (if_enable),
   .tx_enable    (tx_enable),
   .slot_sel     (slot_sel),
   .clr_underrun (clr_underrun),
   .irq_mask     (irq_mask),
   .sink_valid   (sink_valid),
   .sink_ready   (sink_ready),
   .st_empty     (st_empty),
   .st_half      (st_half),
   .st_full      (st_full),
   .st_underrun  (st_underrun),
   .irq          (irq)
);

// File: tb/audio_tx_fifo_bench.sv
module audio_tx_fifo_bench;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_enable = 1'b0, tx_enable = 1'b0, compact_req = 1'b0, wr_valid = 1'b0;
   logic [1:0]  slot_sel = 2'b00, size_code = 2'd0;
   logic [31:0] wr_data = '0;
   logic        clr_underrun = 1'b0, sink_ready = 1'b0;
   logic [2:0]  irq_mask = 3'b000;
   logic        sink_valid, st_empty, st_half, st_full, st_underrun, irq;
   logic [39:0] sink_data;
   logic [6:0]  int_raw;

   int checks = 0;
   int errors = 0;
   logic [19:0] expq [$];

   always #2.5 clk = ~clk;

   audio_tx_fifo #(.DEPTH(DEPTH)) u_audio_tx_fifo (
      .clk(clk), .rst_n(rst_n), .if_enable(if_enable), .tx_enable(tx_enable),
      .slot_sel(slot_sel), .size_code(size_code), .compact_req(compact_req),
      .wr_valid(wr_valid), .wr_data(wr_data), .clr_underrun(clr_underrun),
      .irq_mask(irq_mask), .sink_valid(sink_valid), .sink_ready(sink_ready),
      .sink_data(sink_data), .st_empty(st_empty), .st_half(st_half),
      .st_full(st_full), .st_underrun(st_underrun), .int_raw(int_raw), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   // Expected 20-bit image of a sample of the given width.
   function automatic logic [19:0] model_pad(input logic [31:0] v, input int bits);
      logic [31:0] m;
      m = v & ((32'd1 << bits) - 1);
      return 20'((m * (32'd1 << (20 - bits))) & 32'hFFFFF);
   endfunction

   function automatic int width_of(input logic [1:0] code);
      case (code)
         2'd0: return 16;
         2'd1: return 18;
         2'd2: return 20;
         default: return 12;
      endcase
   endfunction

   // Driver: compute acceptance from the queue, then strobe the write.
   task automatic wr(input logic [31:0] d, input logic [1:0] code, input logic cmp);
      int w;
      w = width_of(code);
      if (if_enable) begin
         if (cmp && (w == 16 || w == 12)) begin
            if (expq.size() + 2 < DEPTH) begin
               expq.push_back(model_pad({16'h0, d[15:0]}, w));
               expq.push_back(model_pad({16'h0, d[31:16]}, w));
            end
         end else if (expq.size() < DEPTH) begin
            expq.push_back(model_pad(d, w));
         end
      end
      size_code = code; compact_req = cmp; wr_data = d; wr_valid = 1'b1;
      step();
      wr_valid = 1'b0;
   endtask

   // Monitor: every handshake must carry the two oldest expected samples.
   always @(negedge clk) begin
      if (rst_n && sink_valid && sink_ready) begin
         checks++;
         if (expq.size() < 2) begin
            errors++;
            $display("FAIL R5: actual pair 0x%0h expected no pair", sink_data);
         end else begin
            if (sink_data !== {expq[0], expq[1]}) begin
               errors++;
               $display("FAIL R2/R3/R5: actual 0x%0h expected 0x%0h", sink_data, {expq[0], expq[1]});
            end
            void'(expq.pop_front());
            void'(expq.pop_front());
         end
      end
   end

   task automatic wait_empty();
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (st_empty) break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R10 raw status
      chk("R1 empty", st_empty, 1);
      chk("R1 half", st_half, 1);
      chk("R1 full", st_full, 0);
      chk("R1 underrun", st_underrun, 0);
      chk("R1 valid", sink_valid, 0);
      chk("R10 int_raw", int_raw, 7'b0000110);
      chk("R10 irq masked", irq, 0);

      step(); if_enable = 1'b1; irq_mask = 3'b111;
      // R2 single-mode alignment for each width
      wr(32'h0000ABCD, 2'd0, 1'b0);
      wr(32'h00FFF123, 2'd3, 1'b0);
      wr(32'h0003FFFF, 2'd1, 1'b0);
      wr(32'h12345678, 2'd2, 1'b0);
      @(negedge clk);
      chk("R7 empty clr", st_empty, 0);
      chk("R7 half clr", st_half, 0);
      chk("R7 full", st_full, 0);
      chk("R10 int_raw", int_raw, 7'b0);
      chk("R10 irq", irq, 0);

      step();
      // R3 packed 16-bit, R4 drop of packed write at level 6
      wr(32'h11112222, 2'd0, 1'b1);
      wr(32'h33334444, 2'd0, 1'b1);
      // R3 packing ignored at 18 bits
      wr(32'h00000001, 2'd1, 1'b1);
      wr(32'h00000005, 2'd2, 1'b0);
      @(negedge clk);
      chk("R7 full set", st_full, 1);
      step();
      wr(32'h00009999, 2'd0, 1'b0);
      @(negedge clk);
      chk("R4 full held", st_full, 1);
      chk("R4 queue depth", expq.size(), 8);

      // R5 gating on slot selects
      step(); tx_enable = 1'b1; slot_sel = 2'b00;
      @(negedge clk);
      chk("R5 no slot", sink_valid, 0);
      step(); slot_sel = 2'b01;
      @(negedge clk);
      chk("R5 valid", sink_valid, 1);
      chk("R5 pair order", sink_data, {expq[0], expq[1]});
      step(); sink_ready = 1'b1;
      wait_empty();
      chk("R6 drained below half", st_empty, 1);
      chk("R8 underrun", st_underrun, 1);
      chk("R8 half", st_half, 1);
      chk("R8 full clr", st_full, 0);
      @(negedge clk);
      chk("R10 int_raw", int_raw, 7'b0000111);
      step(); irq_mask = 3'b001; sink_ready = 1'b0;
      @(negedge clk);
      chk("R10 irq underrun", irq, 1);
      step(); clr_underrun = 1'b1;
      step(); clr_underrun = 1'b0;
      @(negedge clk);
      chk("R9 cleared", st_underrun, 0);
      chk("R10 irq low", irq, 0);

      // R6 refusal ends a burst
      step(); tx_enable = 1'b0;
      wr(32'h0ABC0DEF, 2'd3, 1'b1);
      wr(32'h01230456, 2'd3, 1'b1);
      tx_enable = 1'b1; slot_sel = 2'b10;
      @(negedge clk);
      chk("R5 start at half", sink_valid, 1);
      step(); sink_ready = 1'b1;
      step(); sink_ready = 1'b0;
      @(negedge clk);
      chk("R6 burst holds", sink_valid, 1);
      chk("R8 half set", st_half, 1);
      step();
      @(negedge clk);
      chk("R6 refused", sink_valid, 0);
      sink_ready = 1'b1;
      step();
      @(negedge clk);
      chk("R5 below half idle", sink_valid, 0);
      step(); sink_ready = 1'b0; tx_enable = 1'b0;
      wr(32'h00000007, 2'd0, 1'b0);
      wr(32'h00000008, 2'd0, 1'b0);
      tx_enable = 1'b1; sink_ready = 1'b1;
      wait_empty();
      chk("R8 underrun again", st_underrun, 1);

      // R7 push clears underrun; R1 interface disable
      step(); sink_ready = 1'b0; tx_enable = 1'b0;
      wr(32'h00000042, 2'd2, 1'b0);
      @(negedge clk);
      chk("R7 underrun clr", st_underrun, 0);
      step(); if_enable = 1'b0;
      step(); expq.delete();
      @(negedge clk);
      chk("R1 flush empty", st_empty, 1);
      chk("R1 flush half", st_half, 1);
      wr(32'h00000077, 2'd0, 1'b0);
      if_enable = 1'b1;
      @(negedge clk);
      chk("R1 write ignored", st_empty, 1);
      chk("R1 queue", expq.size(), 0);

      repeat (3) step();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule